// File: doc/BRIEF.md
# Edge-Selectable GPIO Interrupt Controller

This block gives a host processor eight general-purpose input pins, eight general-purpose output pins and one interrupt pin. Each input is synchronized into the core clock domain. A transition on an input sets a sticky flag for that pin. A per-pin select bit chooses whether a rising or a falling transition counts as the active edge.

Software enables the flags one by one, and a global enable gates them all. Together these decide whether a pending flag reaches the interrupt pin. The pin can work in two modes:

- Level mode: the pin stays asserted for as long as any enabled flag is pending.
- Pulse mode: the pin gives a fixed-width pulse each time the set of enabled pending flags goes from empty to non-empty.

A configuration bit selects the pin's polarity in both modes. A processor that does not want interrupts can poll the flag outputs instead, since the flags are set whatever the enable state. Software clears a flag by presenting a one on that flag's clear strobe for one cycle.

The register accesses arrive as plain ports. The serial transport that carries them sits outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the flags, the output pins and the synchronized input values are all zero, and the interrupt pin sits at its inactive level, which is the inverse of irq_pol_i.
- R2: When out_we_i is high at a clock edge, pin_out_o takes out_wdata_i from that edge on. While out_we_i is low, pin_out_o holds its value.
- R3: in_val_o follows pin_in_i through a two-flop synchronizer. A change on an input is visible on in_val_o two clock edges later, and not after only one edge.
- R4: When edge_sel_i bit n is 1, a 0-to-1 transition on input n sets flag n. When the bit is 0, a 1-to-0 transition sets it. Transitions in the other direction leave the flag alone. The flag is visible on flag_o three clock edges after the input changes.
- R5: A flag stays set until its bit in flag_clr_i is 1 at a clock edge. Clear bits that are set for other pins do not affect it.
- R6: If an active edge on a pin is detected in the same cycle that the pin's clear bit is applied, the flag remains set.
- R7: In level mode (irq_mode_i = 0), irq_o is active whenever any flag is set with its irq_en_i bit also set. The active level is high when irq_pol_i = 1 and low when irq_pol_i = 0.
- R8: In pulse mode (irq_mode_i = 1), irq_o goes active for exactly PULSE_W cycles, starting one cycle after the enabled pending set goes from empty to non-empty. No further pulse is produced while that set stays non-empty.
- R9: When glob_en_i is 0, irq_o stays inactive and the flags are still set. Raising glob_en_i while enabled flags are pending makes irq_o active.
- R10: A flag whose irq_en_i bit is 0 still sets in flag_o, so it can be polled, but it does not activate irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_in_i | input | 8 | General-purpose input pins (asynchronous) |
| in_val_o | output | 8 | Synchronized input values |
| out_we_i | input | 1 | Write strobe for the output register |
| out_wdata_i | input | 8 | Data for the output register |
| pin_out_o | output | 8 | General-purpose output pins |
| edge_sel_i | input | 8 | Per-pin active edge: 1 = rising, 0 = falling |
| flag_clr_i | input | 8 | Per-pin write-one-to-clear strobe |
| flag_o | output | 8 | Sticky interrupt flags |
| irq_en_i | input | 8 | Per-pin interrupt enables |
| glob_en_i | input | 1 | Global interrupt enable |
| irq_mode_i | input | 1 | 0 = level signalling, 1 = pulse signalling |
| irq_pol_i | input | 1 | 1 = active-high interrupt pin, 0 = active-low |
| irq_o | output | 1 | Interrupt pin to the host |

## Verification
The assertions check several rules on every cycle:

- each synchronizer stage copies the stage before it;
- a flag never drops without a clear strobe;
- an active edge always sets its flag, including when a clear arrives in the same cycle;
- a pulse starts right after the pending set becomes non-empty, and the pulse counter stays within bounds;
- the output register captures its write data.

Some behaviours need the directed scenarios to show them. These are the exact three-edge latency from pin to flag, the rejection of the opposite edge, the exact pulse width, and the absence of a second pulse while flags stay pending. The scenarios also cover polarity inversion in both modes and the polling path through disabled flags.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic {
    IRQ_LEVEL = 1'b0,
    IRQ_PULSE = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_chk
    assert_sync_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stg_q[k] == $past(stg_q[k-1]));
  end
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q, hit;

  always_comb begin
    if (rise_sel_i) hit = lvl_i & ~prev_q;
    else            hit = ~lvl_i & prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // a new edge wins over a same-cycle clear
      flag_q <= (flag_q & ~clr_i) | hit;
    end
  end

  assign flag_o = flag_q;

  assert_edge_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_sel_i ? (lvl_i && !prev_q) : (!lvl_i && prev_q)) |=> flag_q);
  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  assert_clear_works_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (lvl_i == prev_q)) |=> !flag_q);
  assert_clr_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && rise_sel_i && lvl_i && !prev_q) |=> flag_q);
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out
  import gpio_irq_pkg::*;
#(
  parameter int N       = 8,
  parameter int PULSE_W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  input  logic         glob_en_i,
  input  irq_mode_e    mode_i,
  input  logic         pol_i,
  output logic         irq_o
);
  localparam int CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

  logic          active, active_q, raw;
  logic [CW-1:0] cnt_q;

  assign active = glob_en_i & (|(flag_i & en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active;
      if (mode_i == IRQ_PULSE && active && !active_q) cnt_q <= LOAD;
      else if (cnt_q != '0)                           cnt_q <= cnt_q - 1'b1;
    end
  end

  assign raw   = (mode_i == IRQ_LEVEL) ? active : (cnt_q != '0);
  assign irq_o = pol_i ? raw : ~raw;

  assert_pulse_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IRQ_PULSE && active && !active_q && $stable(pol_i) && mode_i == IRQ_PULSE)
      |=> (mode_i != IRQ_PULSE) || (irq_o == pol_i));
  assert_pulse_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
  assert_pulse_decay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !(active && !active_q)) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_glob_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_i && mode_i == IRQ_LEVEL) |-> irq_o == !pol_i);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_in_i,
  output logic [N-1:0] in_val_o,
  input  logic         out_we_i,
  input  logic [N-1:0] out_wdata_i,
  output logic [N-1:0] pin_out_o,
  input  logic [N-1:0] edge_sel_i,
  input  logic [N-1:0] flag_clr_i,
  output logic [N-1:0] flag_o,
  input  logic [N-1:0] irq_en_i,
  input  logic         glob_en_i,
  input  logic         irq_mode_i,
  input  logic         irq_pol_i,
  output logic         irq_o
);
  logic [N-1:0] sync_val, out_q, flags;

  gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_in_i),
    .q_o   (sync_val)
  );

  for (genvar n = 0; n < N; n++) begin : g_pin
    gpio_edge_flag u_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (sync_val[n]),
      .rise_sel_i(edge_sel_i[n]),
      .clr_i     (flag_clr_i[n]),
      .flag_o    (flags[n])
    );
  end

  gpio_irq_out #(.N(N), .PULSE_W(PULSE_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flag_i   (flags),
    .en_i     (irq_en_i),
    .glob_en_i(glob_en_i),
    .mode_i   (irq_mode_e'(irq_mode_i)),
    .pol_i    (irq_pol_i),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (out_we_i) out_q <= out_wdata_i;
  end

  assign pin_out_o = out_q;
  assign in_val_o  = sync_val;
  assign flag_o    = flags;

  assert_out_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_i |=> pin_out_o == $past(out_wdata_i));
  assert_out_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_we_i |=> $stable(pin_out_o));
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb_top;
  localparam int PW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0, out_wdata = '0, edge_sel = 8'hFF, clr = '0, en = 8'hFF;
  logic       out_we = 1'b0, glob_en = 1'b1, mode = 1'b0, pol = 1'b1;
  logic [7:0] in_val, pin_out, flags;
  logic       irq;
  int         n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.PULSE_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_in_i(pin_in), .in_val_o(in_val),
    .out_we_i(out_we), .out_wdata_i(out_wdata), .pin_out_o(pin_out),
    .edge_sel_i(edge_sel), .flag_clr_i(clr), .flag_o(flags), .irq_en_i(en),
    .glob_en_i(glob_en), .irq_mode_i(mode), .irq_pol_i(pol), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr = 8'hFF; step(); clr = '0; step();
  endtask

  task automatic t_reset();
    step();
    chk("R1 flags", flags, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 in_val", in_val, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_out();
    out_we = 1'b1; out_wdata = 8'hA5; step(); out_we = 1'b0;
    chk("R2 write", pin_out, 8'hA5);
    out_wdata = 8'h3C; step(2);
    chk("R2 hold", pin_out, 8'hA5);
  endtask

  task automatic t_sync();
    pin_in = 8'h81; step();
    chk("R3 one edge", in_val, 0);
    step();
    chk("R3 two edges", in_val, 8'h81);
    step();
    chk("R4 rising sets", flags, 8'h81);
    clear_all();
  endtask

  task automatic t_edges();
    edge_sel = 8'h0F;
    pin_in = 8'h18; step(2);
    chk("R4 not before third edge", flags, 0);
    step();
    chk("R4 mixed edges", flags, 8'h88);
    clear_all();
    edge_sel = 8'hFF;
    pin_in = 8'h00; step(3);
    chk("R4 falling ignored", flags, 0);
  endtask

  task automatic t_clear();
    pin_in = 8'h06; step(3);
    chk("R5 set", flags, 8'h06);
    clr = 8'h02; step(); clr = '0;
    chk("R5 selective clear", flags, 8'h04);
    step(5);
    chk("R5 sticky", flags, 8'h04);
    clear_all();
    pin_in = 8'h00; step(3);
  endtask

  task automatic t_coinc();
    pin_in = 8'h01; step(3);
    pin_in = 8'h00; step(3);
    pin_in = 8'h01; step(2);
    clr = 8'h01; step(); clr = '0;
    chk("R6 edge beats clear", flags, 8'h01);
    step();
    chk("R6 stays", flags, 8'h01);
    clear_all();
    chk("R6 later clear", flags, 0);
  endtask

  task automatic t_level();
    mode = 1'b0; pol = 1'b1;
    pin_in = 8'h03; step(2);
    chk("R7 idle", irq, 0);
    step();
    chk("R7 level active high", irq, 1);
    pol = 1'b0; step();
    chk("R7 level active low", irq, 0);
    step(3);
    chk("R7 level held", irq, 0);
    clear_all();
    chk("R7 low idle", irq, 1);
    pol = 1'b1; step();
    chk("R7 high idle", irq, 0);
  endtask

  task automatic t_enable();
    en = 8'hFB;
    pin_in = 8'h07; step(3);
    chk("R10 polled flag", flags, 8'h04);
    chk("R10 masked irq", irq, 0);
    en = 8'hFF; step();
    chk("R10 enable", irq, 1);
    clear_all();
  endtask

  task automatic t_glob();
    glob_en = 1'b0;
    pin_in = 8'h0F; step(3);
    chk("R9 flag set", flags, 8'h08);
    chk("R9 masked", irq, 0);
    glob_en = 1'b1; step();
    chk("R9 unmask", irq, 1);
    clear_all();
  endtask

  task automatic t_pulse();
    int hi;
    mode = 1'b1; pol = 1'b1;
    pin_in = 8'h1F; step(3);
    chk("R8 flag no pulse yet", irq, 0);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (i == 0) chk("R8 pulse start", irq, 1);
      if (irq) hi++;
    end
    chk("R8 pulse width", hi, PW);
    pin_in = 8'h3F; hi = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (irq) hi++;
    end
    chk("R8 no retrigger", hi, 0);
    pol = 1'b0; step();
    chk("R8 low idle", irq, 1);
    pol = 1'b1;
    clear_all();
    pin_in = 8'h7F; step(3); hi = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (irq) hi++;
    end
    chk("R8 second pulse", hi, PW);
    clear_all();
    mode = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_out();
    t_sync();
    t_edges();
    t_clear();
    t_coinc();
    t_level();
    t_enable();
    t_glob();
    t_pulse();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule